// File: doc/BRIEF.md
# Debug Watchpoint Address Match Unit

This block holds one hardware data watchpoint. Software programs a control word and a watched address through a simple register-write port. On every data access strobe the unit compares the access address, its byte count, whether it is a load or a store, and the privilege level against the programmed settings. A match produces a one-cycle hit pulse on the cycle after the strobe. An optional link gate lets the hit depend on an external comparator's result.

The watched area is chosen in one of two ways. In byte mode (mask field zero), a per-byte select picks lanes within the 8-byte-aligned doubleword at the watched address. In region mode (mask field 3 to 31), an aligned power-of-two region of 2^mask bytes is watched and the byte select has no effect.

A small configuration state machine holds the armed mode. It has three states: `MODE_OFF`, `MODE_BYTES` and `MODE_REGION`. Every control-word write takes one of three transitions from any state. The *disable* transition goes to `MODE_OFF` when the enable bit is clear, the direction field is 00, or the mask is 1 or 2. The *arm_bytes* transition goes to `MODE_BYTES` for an enabled word with mask 0. The *arm_region* transition goes to `MODE_REGION` for an enabled word with mask of 3 or more. Writes to the address register cause no transition.

A second two-state machine produces the output. `HS_QUIET` moves to `HS_FIRE` on a matching strobe, and `HS_FIRE` goes back to `HS_QUIET` unless another matching strobe arrives.

Top module: `wpt_match_unit`

## Requirements
- R1: After reset, `hit` is 0 and the control word reads as all-zero, so no access hits until software arms the unit.
- R2: With control bit 0 (enable) clear, no access ever hits.
- R3: The direction field, control bits 4:3, works as follows: 01 matches loads only, 10 matches stores only, 11 matches both, and 00 behaves as disabled.
- R4: The privilege field, control bits 2:1, works as follows with `acc_priv` 1 for kernel and 0 for user: 0 never matches, 1 matches kernel only, 2 matches user only, 3 matches both.
- R5: The mask field, control bits 28:24, selects region mode when its value is 3 to 31. The region base is the address register with its low mask bits cleared, and any access inside the 2^mask-byte region hits. Masks up to 31 are honoured, so regions beyond 32 KB work. The byte select field has no effect in this mode.
- R6: Mask values 1 and 2 act as disabled, even for an access exactly at the watched address.
- R7: With mask 0, an access hits only if address bits 63:3 equal the watched address bits 63:3 and any touched byte lane is selected in control bits 12:5 (bit 5+i selects lane i). `acc_size` encodes 0/1/2/3 as 1/2/4/8 bytes, and accesses are naturally aligned.
- R8: With mask 0 and watched-address bit 2 set, only select bits for lanes 7:4 count. Lanes 3:0 are never selected.
- R9: With control bit 20 (linked type) set, a hit also requires `link_match` high during the strobe.
- R10: Control bits 13, 15:14, 19:16 and 29 (mode, security, link number and extension filters) have no effect on hits.
- R11: Register writes (`reg_wr_sel` 0 for the control word, 1 for the address) take effect for strobes in the cycle after the write. A strobe in the write cycle uses the old settings.
- R12: `hit` rises on the clock edge that samples a matching strobe and stays high for exactly one cycle per matching strobe. It is 0 after a cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 selects the control word, 1 selects the watched address |
| reg_wr_data | input | 64 | Write data |
| acc_valid | input | 1 | Data access strobe |
| acc_addr | input | 64 | Access byte address |
| acc_size | input | 2 | Log2 of access byte count |
| acc_is_store | input | 1 | 1 for a store, 0 for a load |
| acc_priv | input | 1 | 1 for kernel, 0 for user |
| link_match | input | 1 | Result of the linked comparator |
| hit | output | 1 | One-cycle watchpoint hit |

## Verification
A wrong armed mode cannot be seen directly. It shows as a missing or spurious `hit` on the cycle after the next strobe. For this reason every configuration is probed with strobes placed on both sides of each region edge and byte lane. A corrupted direction, privilege or link filter likewise shows only one cycle after a strobe that should have been blocked. Stuck output state shows as `hit` remaining high in the idle cycle that follows a strobe.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

    localparam int DATA_W  = 64;
    localparam int MASK_W  = 5;
    localparam int SEL_W   = 8;

    // control word field positions (software-visible layout)
    localparam int F_EN    = 0;
    localparam int F_PRIV  = 1;
    localparam int F_DIR   = 3;
    localparam int F_SEL   = 5;
    localparam int F_LINK  = 20;
    localparam int F_MASK  = 24;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_BYTES  = 2'd1,
        MODE_REGION = 2'd2
    } wpt_mode_e;

    typedef enum logic {
        HS_QUIET = 1'b0,
        HS_FIRE  = 1'b1
    } wpt_hit_e;

    typedef struct packed {
        logic [1:0]        priv;
        logic [1:0]        dir;
        logic [SEL_W-1:0]  sel;
        logic              linked;
        logic [MASK_W-1:0] mask;
    } wpt_cfg_t;

    function automatic wpt_cfg_t unpack_ctrl(input logic [DATA_W-1:0] w);
        wpt_cfg_t c;
        c.priv   = w[F_PRIV +: 2];
        c.dir    = w[F_DIR  +: 2];
        c.sel    = w[F_SEL  +: SEL_W];
        c.linked = w[F_LINK];
        c.mask   = w[F_MASK +: MASK_W];
        return c;
    endfunction

    function automatic wpt_mode_e classify(input logic [DATA_W-1:0] w);
        logic [MASK_W-1:0] m;
        m = w[F_MASK +: MASK_W];
        if (!w[F_EN] || (w[F_DIR +: 2] == 2'b00) ||
            (m == MASK_W'(1)) || (m == MASK_W'(2)))
            return MODE_OFF;
        else if (m == '0)
            return MODE_BYTES;
        else
            return MODE_REGION;
    endfunction

endpackage

// File: rtl/wpt_regs.sv
module wpt_regs
    import wpt_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output wpt_cfg_t          cfg_q,
    output wpt_mode_e         mode_q,
    output logic [ADDR_W-1:2] value_q
);

    wpt_mode_e mode_d;
    logic      ctrl_wr;
    logic      addr_wr;

    assign ctrl_wr = wr_en && !wr_sel;
    assign addr_wr = wr_en &&  wr_sel;

    // next-state: every control write takes disable / arm_bytes / arm_region
    always_comb begin
        mode_d = mode_q;
        if (ctrl_wr) begin
            unique case (classify(wr_data))
                MODE_OFF:    mode_d = MODE_OFF;
                MODE_BYTES:  mode_d = MODE_BYTES;
                MODE_REGION: mode_d = MODE_REGION;
                default:     mode_d = MODE_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            value_q <= '0;
        end else begin
            if (ctrl_wr) cfg_q   <= unpack_ctrl(wr_data);
            if (addr_wr) value_q <= wr_data[ADDR_W-1:2];
        end
    end

    AST_REGION_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_REGION) |-> (cfg_q.mask >= MASK_W'(3))); // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_wr |=> $stable(value_q)); // R11

endmodule

// File: rtl/wpt_access_match.sv
module wpt_access_match
    import wpt_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int DW_BYTES = 8
) (
    input  wpt_cfg_t                       cfg,
    input  wpt_mode_e                      mode,
    input  logic [ADDR_W-1:2]              value,
    input  logic [ADDR_W-1:0]              acc_addr,
    input  logic [$clog2($clog2(DW_BYTES)+1)-1:0] acc_size,
    input  logic                           acc_is_store,
    input  logic                           acc_priv,
    input  logic                           link_match,
    output logic                           match
);

    localparam int OFF_W = $clog2(DW_BYTES);
    localparam int CNT_W = OFF_W + 2;
    localparam int HALF  = DW_BYTES / 2;

    logic [DW_BYTES-1:0] lane_touch;
    logic [DW_BYTES-1:0] lane_sel;
    logic [CNT_W-1:0]    first_lane;
    logic [CNT_W-1:0]    nbytes;
    logic                dw_same;
    logic                lane_hit;
    logic [ADDR_W-1:0]   keep;
    logic [ADDR_W-1:0]   value_full;
    logic                region_hit;
    logic                dir_ok, priv_ok, link_ok, where_ok;

    assign first_lane = CNT_W'(acc_addr[OFF_W-1:0]);
    assign nbytes     = CNT_W'(1) << acc_size;

    // per-lane coverage of the access
    for (genvar i = 0; i < DW_BYTES; i++) begin : g_lane
        localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
        assign lane_touch[i] = (IDX >= first_lane) && (IDX < first_lane + nbytes);
    end

    // upper-half watch address drops the lower half of the select
    assign lane_sel = value[OFF_W-1] ? {cfg.sel[DW_BYTES-1:HALF], {HALF{1'b0}}}
                                     : cfg.sel;

    assign dw_same  = (acc_addr[ADDR_W-1:OFF_W] == value[ADDR_W-1:OFF_W]);
    assign lane_hit = |(lane_touch & lane_sel);

    assign value_full = {value, 2'b00};
    assign keep       = {ADDR_W{1'b1}} << cfg.mask;
    assign region_hit = (((acc_addr ^ value_full) & keep) == '0);

    assign dir_ok  = acc_is_store ? cfg.dir[1] : cfg.dir[0];
    assign priv_ok = acc_priv ? cfg.priv[0] : cfg.priv[1];
    assign link_ok = !cfg.linked || link_match;

    always_comb begin
        unique case (mode)
            MODE_BYTES:  where_ok = dw_same && lane_hit;
            MODE_REGION: where_ok = region_hit;
            default:     where_ok = 1'b0;
        endcase
    end

    assign match = where_ok && dir_ok && priv_ok && link_ok;

    always_comb begin
        if (mode == MODE_OFF)
            AST_OFF_NEVER_MATCH: assert (!match); // R2
    end

endmodule

// File: rtl/wpt_match_unit.sv
module wpt_match_unit
    import wpt_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int DW_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_wr_sel,
    input  logic [63:0]       reg_wr_data,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic              acc_is_store,
    input  logic              acc_priv,
    input  logic              link_match,
    output logic              hit
);

    wpt_cfg_t          cfg_q;
    wpt_mode_e         mode_q;
    logic [ADDR_W-1:2] value_q;
    logic              match;
    wpt_hit_e          hs_q, hs_d;

    wpt_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_sel  (reg_wr_sel),
        .wr_data (reg_wr_data),
        .cfg_q   (cfg_q),
        .mode_q  (mode_q),
        .value_q (value_q)
    );

    wpt_access_match #(.ADDR_W(ADDR_W), .DW_BYTES(DW_BYTES)) i_match (
        .cfg          (cfg_q),
        .mode         (mode_q),
        .value        (value_q),
        .acc_addr     (acc_addr),
        .acc_size     (acc_size),
        .acc_is_store (acc_is_store),
        .acc_priv     (acc_priv),
        .link_match   (link_match),
        .match        (match)
    );

    always_comb begin
        unique case (hs_q)
            HS_QUIET: hs_d = (acc_valid && match) ? HS_FIRE : HS_QUIET;
            HS_FIRE:  hs_d = (acc_valid && match) ? HS_FIRE : HS_QUIET;
            default:  hs_d = HS_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= HS_QUIET;
        else        hs_q <= hs_d;
    end

    always_comb hit = (hs_q == HS_FIRE);

    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && mode_q == MODE_OFF) |=> !hit); // R2
    AST_DIR_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cfg_q.dir == 2'b01 && acc_is_store) |=> !hit); // R3
    AST_PRIV_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cfg_q.priv == 2'b00) |=> !hit); // R4
    AST_LINK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cfg_q.linked && !link_match) |=> !hit); // R9
    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !hit); // R12
    AST_WRITE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wr_sel && !reg_wr_data[0]) |=> (mode_q == MODE_OFF)); // R11

endmodule

// File: tb/test_wpt_match_unit.sv
module test_wpt_match_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [63:0] reg_wr_data = '0;
    logic        acc_valid = 1'b0;
    logic [63:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_is_store = 1'b0;
    logic        acc_priv = 1'b0;
    logic        link_match = 1'b0;
    logic        hit;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit exp_q[$];
    string tag_q[$];
    logic pend = 1'b0;

    always #5 clk = ~clk;

    wpt_match_unit i_wpt_match_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_is_store(acc_is_store), .acc_priv(acc_priv),
        .link_match(link_match), .hit(hit)
    );

    function automatic logic [63:0] mkctrl(input bit e, input logic [1:0] pv,
            input logic [1:0] dr, input logic [7:0] sl, input bit lk, input logic [4:0] mk);
        logic [63:0] c = '0;
        c[0] = e; c[2:1] = pv; c[4:3] = dr; c[12:5] = sl; c[20] = lk; c[28:24] = mk;
        return c;
    endfunction

    // monitor: compare hit one cycle after each sampled strobe
    always @(posedge clk) pend <= acc_valid;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (hit !== e) begin
                    failures++;
                    $display("FAIL %s: hit=%0b expected=%0b", t, hit, e);
                end
            end else begin
                checks++;
                if (hit !== 1'b0) begin
                    failures++;
                    $display("FAIL R12 idle cycle: hit=%0b expected=0", hit);
                end
            end
        end
    end

    task automatic drive(input bit we, input bit sel, input logic [63:0] d, input bit av,
            input logic [63:0] a, input logic [1:0] sz, input bit st, input bit pr,
            input bit lk, input bit e, input string t);
        @(negedge clk);
        reg_wr_en = we; reg_wr_sel = sel; reg_wr_data = d;
        acc_valid = av; acc_addr = a; acc_size = sz; acc_is_store = st;
        acc_priv = pr; link_match = lk;
        if (av) begin
            exp_q.push_back(e);
            tag_q.push_back(t);
        end
    endtask

    task automatic wr(input bit sel, input logic [63:0] d);
        drive(1'b1, sel, d, 1'b0, '0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "");
    endtask

    task automatic acc(input logic [63:0] a, input logic [1:0] sz, input bit st,
            input bit pr, input bit lk, input bit e, input string t);
        drive(1'b0, 1'b0, '0, 1'b1, a, sz, st, pr, lk, e, t);
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, '0, 1'b0, '0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (hit !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: hit=%0b expected=0", hit);
        end
        acc(64'h0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R1 unarmed after reset");

        // byte mode, all lanes
        wr(1'b1, 64'h1000);
        wr(1'b0, mkctrl(1, 2'd3, 2'd3, 8'hFF, 0, 5'd0));
        acc(64'h1000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R7 same doubleword");
        acc(64'h1008, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R7 next doubleword");
        acc(64'h0FF8, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, "R7 previous doubleword");
        wr(1'b0, mkctrl(0, 2'd3, 2'd3, 8'hFF, 0, 5'd0));
        acc(64'h1000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R2 enable clear");

        // direction
        wr(1'b0, mkctrl(1, 2'd3, 2'd1, 8'hFF, 0, 5'd0));
        acc(64'h1000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R3 load-only load");
        acc(64'h1000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 load-only store");
        wr(1'b0, mkctrl(1, 2'd3, 2'd2, 8'hFF, 0, 5'd0));
        acc(64'h1000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R3 store-only load");
        acc(64'h1000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R3 store-only store");
        wr(1'b0, mkctrl(1, 2'd3, 2'd0, 8'hFF, 0, 5'd0));
        acc(64'h1000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 direction 00 disabled");

        // privilege
        wr(1'b0, mkctrl(1, 2'd1, 2'd3, 8'hFF, 0, 5'd0));
        acc(64'h1000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R4 kernel-only kernel");
        acc(64'h1000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 kernel-only user");
        wr(1'b0, mkctrl(1, 2'd2, 2'd3, 8'hFF, 0, 5'd0));
        acc(64'h1000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R4 user-only user");
        acc(64'h1000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R4 user-only kernel");
        wr(1'b0, mkctrl(1, 2'd0, 2'd3, 8'hFF, 0, 5'd0));
        acc(64'h1000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R4 privilege 0");

        // byte lanes
        wr(1'b1, 64'h2001);
        wr(1'b0, mkctrl(1, 2'd3, 2'd3, 8'h04, 0, 5'd0));
        acc(64'h2002, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R7 lane 2 byte");
        acc(64'h2003, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R7 lane 3 byte");
        acc(64'h2000, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, "R7 halfword lanes 0-1");
        acc(64'h2000, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, "R7 word lanes 0-3");
        acc(64'h2000, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, "R7 doubleword");

        // upper half
        wr(1'b1, 64'h2004);
        wr(1'b0, mkctrl(1, 2'd3, 2'd3, 8'h0F, 0, 5'd0));
        acc(64'h2000, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, "R8 low selects dropped");
        wr(1'b0, mkctrl(1, 2'd3, 2'd3, 8'h11, 0, 5'd0));
        acc(64'h2004, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R8 lane 4 selected");
        acc(64'h2000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R8 lane 0 ignored");

        // region mode, 64 KB
        wr(1'b1, 64'h12345);
        wr(1'b0, mkctrl(1, 2'd3, 2'd3, 8'h00, 0, 5'd16));
        acc(64'h10000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R5 region base");
        acc(64'h1FFF8, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, "R5 region top");
        acc(64'h20000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 above region");
        acc(64'h0FFF8, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, "R5 below region");
        wr(1'b1, 64'h1_8000_1234);
        wr(1'b0, mkctrl(1, 2'd3, 2'd3, 8'h00, 0, 5'd31));
        acc(64'h1_FFFF_FFF0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, "R5 2 GB region inside");
        acc(64'h2_0000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R5 2 GB region outside");
        wr(1'b1, 64'h3005);
        wr(1'b0, mkctrl(1, 2'd3, 2'd3, 8'h00, 0, 5'd3));
        acc(64'h3007, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R5 select ignored");

        // reserved masks
        wr(1'b0, mkctrl(1, 2'd3, 2'd3, 8'hFF, 0, 5'd1));
        acc(64'h3004, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R6 mask 1");
        wr(1'b0, mkctrl(1, 2'd3, 2'd3, 8'hFF, 0, 5'd2));
        acc(64'h3004, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R6 mask 2");

        // linked
        wr(1'b0, mkctrl(1, 2'd3, 2'd3, 8'h00, 1, 5'd3));
        acc(64'h3000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R9 link low");
        acc(64'h3000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, "R9 link high");

        // ignored filter fields
        wr(1'b0, mkctrl(1, 2'd3, 2'd3, 8'h00, 0, 5'd3) | 64'h2000_0000 | 64'h000F_0000
                 | 64'h0000_8000 | 64'h0000_2000);
        acc(64'h3000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R10 extra fields");

        // write latency
        wr(1'b0, mkctrl(0, 2'd3, 2'd3, 8'h00, 0, 5'd3));
        drive(1'b1, 1'b0, mkctrl(1, 2'd3, 2'd3, 8'h00, 0, 5'd3), 1'b1,
              64'h3000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R11 control write cycle");
        acc(64'h3000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R11 control next cycle");
        drive(1'b1, 1'b1, 64'h5000, 1'b1,
              64'h5000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R11 address write cycle");
        acc(64'h5000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R11 address next cycle");

        // back-to-back hits then idle
        acc(64'h5001, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R12 back-to-back first");
        acc(64'h5002, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R12 back-to-back second");
        idle();
        idle();
        idle();

        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R12 pending results=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule